// File: doc/BRIEF.md
# ATM Transmit Cell Generator

This block sits between a cell FIFO and a line framer transmitter and keeps the transmit octet stream filled with 53-octet ATM cells. A cell has a 5-octet header and a 48-octet payload. The framer pulls octets with an octet-enable strobe. For each enabled clock the block presents one octet, and it marks the first header octet of every cell with a start-of-cell strobe.

At every cell boundary the block checks the FIFO's cell-ready flag. If the flag is low, it sends an idle cell. The idle cell's four header octets and its payload fill octet come from configuration inputs. If the flag is high, it sends a user cell in one of four modes:
- **Header generation:** the four header octets come from a configuration word and the 48 payload octets come from the FIFO.
- **HEC-only generation:** 52 FIFO octets supply the header and the payload.
- **Pass-through:** the FIFO supplies a complete 53-octet cell.
- **Extended pass-through:** the FIFO supplies a 57-octet cell, and the slot grows to 57 octets.

In every cell the fifth octet is a freshly computed header error check. A configuration bit selects whether that check covers four header octets or only three.

A cell is never shortened. If cell-ready falls while FIFO octets are still owed, the block flags an underrun on that octet. It then sends the fill octet in every remaining FIFO-sourced position and completes the slot at full length.

Top module: `atm_cell_gen`

## Requirements
- R1: After synchronous reset, `out_valid`, `out_soc`, `out_underrun` and `fifo_rd` are 0, and the first enabled octet after reset is octet 1 of a new cell.
- R2: Each `tx_en` clock emits exactly one octet, registered with `out_valid` in the following cycle. A slot has 53 octets, or 57 octets in mode 3. `out_soc` is high only with octet 1 of a slot. Clocks without `tx_en` do not advance the slot.
- R3: If `fifo_rdy` is low on the enabled clock of octet 1, the slot is an idle cell. Octets 1 to 4 are `cfg_idle_hdr` with bits 31:24 first, octet 5 is the HEC, and every later octet is `cfg_idle_fill`. No FIFO octet is read.
- R4: Mode 0 (`cfg_mode`=0): octets 1 to 4 come from `cfg_hdr` with bits 31:24 first, octet 5 is the HEC, and octets 6 to 53 are 48 consecutive FIFO octets.
- R5: The HEC is a CRC-8 with polynomial x^8+x^2+x+1, initial value 0, fed MSB first and XORed with 0x55. It covers the transmitted octets 1 to 4 when `cfg_hec4`=1 and octets 1 to 3 when `cfg_hec4`=0.
- R6: Mode 1: octets 1 to 4 and 6 to 53 are 52 consecutive FIFO octets, and no FIFO octet is read for octet 5.
- R7: Mode 2: all 53 octets are read from the FIFO. The fifth FIFO octet is discarded and replaced by the HEC.
- R8: Mode 3: all 57 octets of a 57-octet slot are read from the FIFO, and the fifth is replaced by the HEC.
- R9: In a user cell, a FIFO-sourced octet that falls due while `fifo_rdy` is low raises `out_underrun` alongside that octet only. That octet and every later FIFO-sourced octet of the cell carry `cfg_idle_fill`, no further FIFO read occurs, and the slot keeps its full length.
- R10: Changes to `cfg_mode` and `cfg_hec4` after octet 1 have no effect until the next slot.
- R11: `fifo_rd` is high only in a clock with `tx_en` and `fifo_rdy` high whose octet is FIFO-sourced, and `fifo_data` is taken in that clock. The number of reads per cell equals the number of FIFO octets the mode consumes, or the number available before an underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Framer octet enable; one octet per high clock |
| cfg_mode | input | 2 | Cell mode: 0 header generation, 1 HEC-only, 2 pass 53, 3 pass 57 |
| cfg_hec4 | input | 1 | 1: HEC covers four header octets; 0: three |
| cfg_hdr | input | 32 | Header octets 1..4 for mode 0 user cells |
| cfg_idle_hdr | input | 32 | Header octets 1..4 for idle cells |
| cfg_idle_fill | input | 8 | Idle payload and underrun pad octet |
| fifo_rdy | input | 1 | FIFO has cell data ready |
| fifo_data | input | 8 | FIFO octet, taken when fifo_rd is high |
| fifo_rd | output | 1 | FIFO octet consumed this clock |
| out_valid | output | 1 | out_data holds a new octet |
| out_data | output | 8 | Transmit octet toward the framer |
| out_soc | output | 1 | Start of cell, with header octet 1 |
| out_underrun | output | 1 | FIFO ran dry inside a user cell at this octet |

## Verification
`fifo_rd` is combinational and is due in the same clock as the `tx_en` it answers. The bench reads it one time unit after it drives the inputs at the falling edge, before the rising edge that consumes the octet. Each output octet, with its start and underrun flags, is due one cycle after its `tx_en` clock. The bench pushes its expected octets into a queue when it starts a slot, and pops one entry at each falling edge where `out_valid` is high, so that enable gaps move the comparison point with the stream. Read counts are compared once the last enabled clock of a cell has been driven, and the reset outputs are compared at the falling edge after the reset edge.

// File: rtl/atm_cg_pkg.sv
package atm_cg_pkg;

    localparam int OCTET_W    = 8;
    localparam int HDR_OCTETS = 4;
    localparam int HDR_W      = HDR_OCTETS * OCTET_W;
    localparam int CELL_STD   = 53;
    localparam int CELL_EXT   = 57;
    localparam int IDX_W      = $clog2(CELL_EXT);
    localparam int SEL_W      = $clog2(HDR_OCTETS);

    localparam logic [OCTET_W-1:0] HEC_POLY  = 8'h07;
    localparam logic [OCTET_W-1:0] HEC_COSET = 8'h55;

    typedef enum logic [1:0] {
        MODE_GEN48  = 2'd0,
        MODE_GEN52  = 2'd1,
        MODE_PASS53 = 2'd2,
        MODE_PASS57 = 2'd3
    } cg_mode_e;

    typedef enum logic [2:0] {
        SRC_CFG_HDR  = 3'd0,
        SRC_IDLE_HDR = 3'd1,
        SRC_FIFO     = 3'd2,
        SRC_HEC      = 3'd3,
        SRC_FILL     = 3'd4
    } cg_src_e;

    typedef struct packed {
        cg_src_e          src;
        logic [SEL_W-1:0] hdr_sel;
        logic             crc_take;
        logic             first;
    } cg_octet_t;

    function automatic logic [OCTET_W-1:0] crc8_step(
        input logic [OCTET_W-1:0] crc_in,
        input logic [OCTET_W-1:0] din
    );
        logic [OCTET_W-1:0] c;
        c = crc_in ^ din;
        for (int b = 0; b < OCTET_W; b++) begin
            c = c[OCTET_W-1] ? ((c << 1) ^ HEC_POLY) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [OCTET_W-1:0] hdr_octet(
        input logic [HDR_W-1:0] word,
        input logic [SEL_W-1:0] sel
    );
        return word[(HDR_OCTETS - 1 - int'(sel)) * OCTET_W +: OCTET_W];
    endfunction

endpackage

// File: rtl/cg_slot_ctrl.sv
module cg_slot_ctrl
    import atm_cg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tx_en,
    input  logic      fifo_rdy,
    input  cg_mode_e  cfg_mode,
    input  logic      cfg_hec4,
    output cg_octet_t oct,
    output logic      fifo_rd,
    output logic      underrun
);

    localparam logic [IDX_W-1:0] IDX_HEC     = IDX_W'(HDR_OCTETS);
    localparam logic [IDX_W-1:0] IDX_LASTHDR = IDX_W'(HDR_OCTETS - 1);
    localparam logic [IDX_W-1:0] LAST_STD    = IDX_W'(CELL_STD - 1);
    localparam logic [IDX_W-1:0] LAST_EXT    = IDX_W'(CELL_EXT - 1);

    logic [IDX_W-1:0] idx_q;
    logic             user_q;
    logic             starved_q;
    cg_mode_e         mode_q;
    logic             hec4_q;

    logic             first;
    cg_mode_e         eff_mode;
    logic             eff_hec4;
    logic             eff_user;
    logic             eff_starved;
    logic [IDX_W-1:0] last_idx;
    logic             fifo_need;

    always_comb begin
        first       = (idx_q == '0);
        eff_mode    = first ? cfg_mode : mode_q;
        eff_hec4    = first ? cfg_hec4 : hec4_q;
        eff_user    = first ? fifo_rdy : user_q;
        eff_starved = first ? 1'b0 : starved_q;
        last_idx    = (eff_mode == MODE_PASS57) ? LAST_EXT : LAST_STD;

        fifo_need    = 1'b0;
        oct          = '0;
        oct.src      = SRC_FILL;
        oct.hdr_sel  = idx_q[SEL_W-1:0];
        oct.first    = first;
        oct.crc_take = (idx_q < IDX_LASTHDR) || ((idx_q == IDX_LASTHDR) && eff_hec4);

        if (idx_q < IDX_HEC) begin
            if (!eff_user) begin
                oct.src = SRC_IDLE_HDR;
            end else if (eff_mode == MODE_GEN48) begin
                oct.src = SRC_CFG_HDR;
            end else begin
                fifo_need = 1'b1;
            end
        end else if (idx_q == IDX_HEC) begin
            oct.src   = SRC_HEC;
            fifo_need = eff_user &&
                        ((eff_mode == MODE_PASS53) || (eff_mode == MODE_PASS57));
        end else begin
            fifo_need = eff_user;
        end

        if (fifo_need && (oct.src != SRC_HEC)) begin
            oct.src = (eff_starved || !fifo_rdy) ? SRC_FILL : SRC_FIFO;
        end

        fifo_rd  = tx_en && fifo_need && !eff_starved && fifo_rdy;
        underrun = tx_en && fifo_need && !eff_starved && !fifo_rdy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            user_q    <= 1'b0;
            starved_q <= 1'b0;
            mode_q    <= MODE_GEN48;
            hec4_q    <= 1'b1;
        end else if (tx_en) begin
            idx_q     <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
            starved_q <= eff_starved || underrun;
            if (first) begin
                mode_q <= cfg_mode;
                hec4_q <= cfg_hec4;
                user_q <= fifo_rdy;
            end
        end
    end

    // R2: slot position never passes the end of its slot
    p_idx_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (idx_q != '0 && mode_q != MODE_PASS57) |-> (idx_q <= LAST_STD));

    // R3: an idle slot never draws on the FIFO
    p_idle_no_read_r3: assert property (@(posedge clk) disable iff (rst)
        (idx_q != '0 && !user_q) |-> !fifo_rd);

    // R9: after an underrun the cell stops reading
    p_starved_no_read_r9: assert property (@(posedge clk) disable iff (rst)
        (idx_q != '0 && starved_q) |-> !fifo_rd);

    // R10: latched mode holds for the rest of a slot
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (idx_q != '0) |=> $stable(mode_q));

    // R11: a read never coincides with an underrun
    p_read_xor_under_r11: assert property (@(posedge clk) disable iff (rst)
        !(fifo_rd && underrun));

endmodule

// File: rtl/cg_hec_accum.sv
module cg_hec_accum
    import atm_cg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic               take,
    input  logic               first,
    input  logic [OCTET_W-1:0] din,
    output logic [OCTET_W-1:0] hec
);

    logic [OCTET_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else if (step && take) begin
            crc_q <= crc8_step(first ? '0 : crc_q, din);
        end
    end

    assign hec = crc_q ^ HEC_COSET;

endmodule

// File: rtl/cg_octet_mux.sv
module cg_octet_mux
    import atm_cg_pkg::*;
(
    input  cg_octet_t          oct,
    input  logic [HDR_W-1:0]   cfg_hdr,
    input  logic [HDR_W-1:0]   idle_hdr,
    input  logic [OCTET_W-1:0] idle_fill,
    input  logic [OCTET_W-1:0] fifo_data,
    input  logic [OCTET_W-1:0] hec,
    output logic [OCTET_W-1:0] octet
);

    always_comb begin
        unique case (oct.src)
            SRC_CFG_HDR:  octet = hdr_octet(cfg_hdr, oct.hdr_sel);
            SRC_IDLE_HDR: octet = hdr_octet(idle_hdr, oct.hdr_sel);
            SRC_FIFO:     octet = fifo_data;
            SRC_HEC:      octet = hec;
            default:      octet = idle_fill;
        endcase
    end

endmodule

// File: rtl/atm_cell_gen.sv
module atm_cell_gen
    import atm_cg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_en,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_hec4,
    input  logic [HDR_W-1:0]   cfg_hdr,
    input  logic [HDR_W-1:0]   cfg_idle_hdr,
    input  logic [OCTET_W-1:0] cfg_idle_fill,
    input  logic               fifo_rdy,
    input  logic [OCTET_W-1:0] fifo_data,
    output logic               fifo_rd,
    output logic               out_valid,
    output logic [OCTET_W-1:0] out_data,
    output logic               out_soc,
    output logic               out_underrun
);

    cg_octet_t          oct;
    logic               underrun;
    logic [OCTET_W-1:0] hec;
    logic [OCTET_W-1:0] octet_byte;

    cg_slot_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .fifo_rdy (fifo_rdy),
        .cfg_mode (cg_mode_e'(cfg_mode)),
        .cfg_hec4 (cfg_hec4),
        .oct      (oct),
        .fifo_rd  (fifo_rd),
        .underrun (underrun)
    );

    cg_octet_mux u_mux (
        .oct       (oct),
        .cfg_hdr   (cfg_hdr),
        .idle_hdr  (cfg_idle_hdr),
        .idle_fill (cfg_idle_fill),
        .fifo_data (fifo_data),
        .hec       (hec),
        .octet     (octet_byte)
    );

    cg_hec_accum u_hec (
        .clk   (clk),
        .rst   (rst),
        .step  (tx_en),
        .take  (oct.crc_take),
        .first (oct.first),
        .din   (octet_byte),
        .hec   (hec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_soc      <= 1'b0;
            out_underrun <= 1'b0;
            out_data     <= '0;
        end else begin
            out_valid    <= tx_en;
            out_soc      <= tx_en && oct.first;
            out_underrun <= underrun;
            if (tx_en) begin
                out_data <= octet_byte;
            end
        end
    end

    // R2: the start strobe only rides on a delivered octet
    p_soc_valid_r2: assert property (@(posedge clk) disable iff (rst)
        out_soc |-> out_valid);

    // R9: the underrun flag only rides on a delivered octet
    p_under_valid_r9: assert property (@(posedge clk) disable iff (rst)
        out_underrun |-> out_valid);

    // R9: octet 1 of a slot can never be an underrun
    p_under_not_soc_r9: assert property (@(posedge clk) disable iff (rst)
        out_soc |-> !out_underrun);

endmodule

// File: tb/atm_cell_gen_test.sv
module atm_cell_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;
    localparam int RING = 256;

    // {mode[11:10], hec4[9], avail[8:2], gap[1], chg[0]}
    localparam logic [11:0] VECS [0:NV-1] = '{
        {2'd0, 1'b1, 7'd0,  1'b0, 1'b0},
        {2'd0, 1'b1, 7'd48, 1'b0, 1'b0},
        {2'd0, 1'b0, 7'd60, 1'b0, 1'b0},
        {2'd1, 1'b1, 7'd52, 1'b0, 1'b0},
        {2'd2, 1'b1, 7'd53, 1'b1, 1'b0},
        {2'd3, 1'b0, 7'd57, 1'b0, 1'b0},
        {2'd0, 1'b1, 7'd20, 1'b0, 1'b0},
        {2'd2, 1'b1, 7'd2,  1'b0, 1'b0},
        {2'd1, 1'b1, 7'd52, 1'b0, 1'b1},
        {2'd3, 1'b1, 7'd0,  1'b1, 1'b0},
        {2'd3, 1'b1, 7'd55, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_hec4 = 1'b1;
    logic [31:0] cfg_hdr = 32'h1234_5678;
    logic [31:0] cfg_idle_hdr = 32'h0000_0001;
    logic [7:0]  cfg_idle_fill = 8'h6A;
    logic        fifo_rdy = 1'b0;
    logic [7:0]  fifo_data = 8'h00;
    logic        fifo_rd;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_soc;
    logic        out_underrun;

    int n_cmp = 0;
    int n_bad = 0;
    int pops_total = 0;
    int pops_cell = 0;
    int cell_avail = 0;
    bit check_en = 1'b1;
    bit done = 1'b0;

    logic [7:0] q_data [0:RING-1];
    logic       q_soc  [0:RING-1];
    logic       q_und  [0:RING-1];
    string      q_tag  [0:RING-1];
    int q_wr = 0;
    int q_rd = 0;

    atm_cell_gen uut (
        .clk           (clk),
        .rst           (rst),
        .tx_en         (tx_en),
        .cfg_mode      (cfg_mode),
        .cfg_hec4      (cfg_hec4),
        .cfg_hdr       (cfg_hdr),
        .cfg_idle_hdr  (cfg_idle_hdr),
        .cfg_idle_fill (cfg_idle_fill),
        .fifo_rdy      (fifo_rdy),
        .fifo_data     (fifo_data),
        .fifo_rd       (fifo_rd),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_soc       (out_soc),
        .out_underrun  (out_underrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input int n);
        return 8'((n * 7) + 3);
    endfunction

    function automatic logic [7:0] word_octet(input logic [31:0] w, input int i);
        return w[(3 - i) * 8 +: 8];
    endfunction

    function automatic logic [7:0] hec_ref(input logic [7:0] b0, input logic [7:0] b1,
                                           input logic [7:0] b2, input logic [7:0] b3,
                                           input logic four);
        logic [7:0] crc;
        logic [31:0] bits;
        int nb;
        crc = 8'h00;
        bits = {b0, b1, b2, b3};
        nb = four ? 32 : 24;
        for (int i = 0; i < nb; i++) begin
            logic fb;
            fb = crc[7] ^ bits[31 - i];
            crc = {crc[6:0], 1'b0};
            if (fb) crc = crc ^ 8'h07;
        end
        return crc ^ 8'h55;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_out();
        if (check_en && out_valid) begin
            if (q_rd == q_wr) begin
                check("R2", "unexpected octet", 1, 0);
            end else begin
                int s;
                s = q_rd % RING;
                check(q_tag[s], "octet", int'(out_data), int'(q_data[s]));
                check("R2", "soc", int'(out_soc), int'(q_soc[s]));
                check("R9", "underrun flag", int'(out_underrun), int'(q_und[s]));
                q_rd++;
            end
        end
    endtask

    task automatic tick(input logic en);
        @(negedge clk);
        check_out();
        tx_en = en;
        fifo_rdy = (pops_cell < cell_avail);
        fifo_data = pat(pops_total);
        #1;
        if (fifo_rd) begin
            pops_total++;
            pops_cell++;
        end
    endtask

    task automatic push(input logic [7:0] d, input logic s, input logic u, input string t);
        q_data[q_wr % RING] = d;
        q_soc[q_wr % RING]  = s;
        q_und[q_wr % RING]  = u;
        q_tag[q_wr % RING]  = t;
        q_wr++;
    endtask

    task automatic run_cell(input logic [1:0] m, input logic h4, input int avail,
                            input logic gap, input logic chg);
        logic [7:0] e [0:56];
        logic       eu [0:56];
        string      et [0:56];
        int  len, k;
        logic starv, user, need;
        string mtag;
        cfg_mode   = m;
        cfg_hec4   = h4;
        cell_avail = avail;
        pops_cell  = 0;
        user  = (avail > 0);
        len   = (m == 2'd3) ? 57 : 53;
        k     = 0;
        starv = 1'b0;
        case (m)
            2'd0: mtag = "R4";
            2'd1: mtag = "R6";
            2'd2: mtag = "R7";
            default: mtag = "R8";
        endcase
        if (chg) mtag = "R10";
        for (int i = 0; i < len; i++) begin
            eu[i] = 1'b0;
            if (!user) begin
                e[i]  = (i < 4) ? word_octet(cfg_idle_hdr, i) : cfg_idle_fill;
                et[i] = "R3";
            end else begin
                et[i] = mtag;
                e[i]  = 8'h00;
                if (i < 4 && m == 2'd0) e[i] = word_octet(cfg_hdr, i);
                need = (i < 4 && m != 2'd0) || (i == 4 && m >= 2'd2) || (i > 4);
                if (need) begin
                    logic [7:0] v;
                    if (!starv && k < avail) begin
                        v = pat(pops_total + k);
                        k++;
                    end else begin
                        if (!starv) eu[i] = 1'b1;
                        starv = 1'b1;
                        v = cfg_idle_fill;
                        et[i] = "R9";
                    end
                    e[i] = v;
                end
            end
            if (i == 4) begin
                e[4]  = hec_ref(e[0], e[1], e[2], e[3], h4);
                et[4] = "R5";
            end
        end
        for (int i = 0; i < len; i++) push(e[i], (i == 0), eu[i], et[i]);
        for (int i = 0; i < len; i++) begin
            if (gap && (i % 3 == 1)) tick(1'b0);
            tick(1'b1);
            if (chg && i == 3) begin
                cfg_mode = 2'd3;
                cfg_hec4 = ~h4;
            end
        end
        check(user ? "R11" : "R3", "fifo reads in cell", pops_cell, k);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog expired: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        tick(1'b0);
        tick(1'b0);
        tick(1'b0);
        // R1: outputs quiet in reset
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_soc in reset", int'(out_soc), 0);
        check("R1", "out_underrun in reset", int'(out_underrun), 0);
        check("R1", "fifo_rd in reset", int'(fifo_rd), 0);
        rst = 1'b0;

        // R5: sanity of the reference HEC on a known idle header
        check("R5", "reference HEC of 00000001", int'(hec_ref(8'h00, 8'h00, 8'h00, 8'h01, 1'b1)), 8'h52);

        for (int v = 0; v < NV; v++) begin
            run_cell(VECS[v][11:10], VECS[v][9], int'(VECS[v][8:2]), VECS[v][1], VECS[v][0]);
        end
        tick(1'b0);
        tick(1'b0);
        check("R2", "expected octets left over", q_wr - q_rd, 0);

        // R1: reset in the middle of a slot restarts at octet 1
        check_en   = 1'b0;
        cfg_mode   = 2'd0;
        cfg_hec4   = 1'b1;
        cell_avail = 0;
        pops_cell  = 0;
        for (int i = 0; i < 10; i++) tick(1'b1);
        rst = 1'b1;
        tick(1'b0);
        tick(1'b0);
        check("R1", "out_valid after mid-cell reset", int'(out_valid), 0);
        check("R1", "out_soc after mid-cell reset", int'(out_soc), 0);
        check("R1", "fifo_rd after mid-cell reset", int'(fifo_rd), 0);
        rst = 1'b0;
        q_rd = q_wr;
        check_en = 1'b1;
        cfg_idle_hdr  = 32'hA5C3_0F10;
        cfg_idle_fill = 8'h3C;
        run_cell(2'd0, 1'b0, 0, 1'b0, 1'b0);
        run_cell(2'd2, 1'b0, 53, 1'b0, 1'b0);
        tick(1'b0);
        tick(1'b0);
        check("R1", "octets left after reset test", q_wr - q_rd, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule